// File: doc/BRIEF.md
# Configurable SPI Master Serial Engine

This block is the serial core of an SPI master. It takes words from a small transmit FIFO and shifts them out on a data pin. At the same time it collects bits from the input pin into a receive FIFO. A set of static configuration inputs controls the frame length, clock polarity and phase, and bit order. The same inputs set how the select line behaves between frames, the lead time before the first clock edge, and which FIFOs take part in a transfer. An integer divider sets the serial clock rate from the system clock. Status flags and interrupt flags report FIFO levels and error events. The interrupt flags can be masked, and the error flags are sticky until cleared.

The engine is a four-state machine. `ST_IDLE` keeps the select high and the clock at its idle level. It moves to `ST_LEAD` when the engine is enabled and a frame is available; that transition loads the first frame. `ST_LEAD` drives the select low and waits one or two half periods, then moves to `ST_SHIFT`. `ST_SHIFT` runs two half periods per bit. At the end of a frame there are three paths. If the gap mode is non-zero it moves to `ST_GAP`. If the gap mode is zero and another frame is ready, it stays in `ST_SHIFT` and loads that frame. Otherwise it returns to `ST_IDLE`. `ST_GAP` holds the select high for one or two half periods. It then moves to `ST_LEAD` if another frame is ready, and to `ST_IDLE` if not.

Top module: `spi_serial_engine`

## Requirements
- R1: `frame_sel` code 0 selects 4-bit frames, code 1 selects 8-bit frames and code 2 selects 16-bit frames. Code 3 behaves like code 1. A frame of N bits produces exactly 2N serial clock transitions.
- R2: While `ss_n` is high, `sclk` equals `cpol`: idle low for 0 and idle high for 1.
- R3: With `cpha`=0 the first clock transition comes one half period after the start of the first bit. With `cpha`=1 it comes at the start of the first bit. Data is captured on the first edge of each bit for `cpha`=0 and on the second edge for `cpha`=1.
- R4: With `lsb_first`=0 the MSB of the frame goes out first; with `lsb_first`=1 the LSB goes out first. Received words are stored in the same numeric orientation.
- R5: `sel_gap` controls the select line between frames. Code 0 keeps `ss_n` low across back-to-back frames. Code 1 raises it for one half period after each frame. Codes 2 and 3 raise it for two half periods.
- R6: The time from `ss_n` falling to the start of the first bit is one half period when `lead_full`=0 and two half periods when `lead_full`=1.
- R7: Mode 0 of `xfer_mode` pops one TX word per frame and pushes one received word per frame.
- R8: Mode 1 of `xfer_mode` discards received bits. Mode 2 drives `mosi` low, leaves the TX FIFO untouched and runs `rx_frames` frames. That count is captured while `en` is low and the engine is idle.
- R9: `status` bits are: bit 0 busy (from select assertion until the engine returns idle), bit 1 TX full, bit 2 TX empty, bit 3 RX empty, bit 4 RX full.
- R10: `int_raw` bits are: bit 0 TX level (TX count at or below `tx_thresh`), bit 1 TX overflow, bit 2 RX underflow, bit 3 RX overflow, bit 4 RX level (RX count at or above `rx_thresh`). `int_out` is `int_raw` ANDed with `int_mask`.
- R11: The overflow and underflow bits stay set until cleared. `clr_all` clears all three. `clr_txo`, `clr_rxu` and `clr_rxo` each clear one. A clear wins over a set in the same cycle.
- R12: One half period of the serial clock lasts `half_div` system clocks; a value of 0 acts as 1.
- R13: A frame starts only when `en` is high and a frame is available. In modes 0 and 1 that means the TX FIFO is not empty; in mode 2 it means the remaining frame count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| frame_sel | input | 2 | Frame length code |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase |
| lsb_first | input | 1 | Bit order select |
| sel_gap | input | 2 | Select behaviour between frames |
| lead_full | input | 1 | Select-to-first-bit lead length |
| xfer_mode | input | 2 | 0 both, 1 transmit only, 2 receive only |
| half_div | input | DIVW | System clocks per serial half period |
| rx_frames | input | CNTW | Frame count for receive-only mode |
| tx_thresh | input | $clog2(DEPTH)+1 | TX level threshold |
| rx_thresh | input | $clog2(DEPTH)+1 | RX level threshold |
| tx_wr | input | 1 | Write strobe into the TX FIFO |
| tx_data | input | 16 | TX word |
| rx_rd | input | 1 | Read strobe from the RX FIFO |
| rx_data | output | 16 | Head of the RX FIFO |
| int_mask | input | 5 | Interrupt mask |
| clr_all | input | 1 | Clear all sticky flags |
| clr_rxu | input | 1 | Clear RX underflow |
| clr_rxo | input | 1 | Clear RX overflow |
| clr_txo | input | 1 | Clear TX overflow |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low select |
| miso | input | 1 | Serial data in |
| status | output | 5 | Status flags |
| int_raw | output | 5 | Raw interrupt flags |
| int_out | output | 5 | Masked interrupt flags |

## Verification
A wrong state or half-period counter shows up at the pins within one frame. It changes the distance from the select falling to the first clock transition, the number of transitions per frame, or the length of the select-high pulse. The bench measures each of these in system clocks. A shift-register or bit-order fault shows up as a wrong word at the capture point on `mosi` one frame later, and as a wrong word at the head of the RX FIFO in loopback. A fault in a flag register shows up on `int_raw` one cycle after the strobe that should set or clear it.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int MAXW = 16;

    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_GAP} eng_state_t;

    localparam logic [1:0] XM_BOTH   = 2'd0;
    localparam logic [1:0] XM_TXONLY = 2'd1;
    localparam logic [1:0] XM_RXONLY = 2'd2;

    function automatic logic [4:0] frame_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd4;
            2'd2:    return 5'd16;
            default: return 5'd8;
        endcase
    endfunction

    function automatic logic [MAXW-1:0] low_mask(input logic [4:0] n);
        return (n >= 5'd16) ? 16'hFFFF : 16'((17'd1 << n) - 17'd1);
    endfunction

    function automatic logic [MAXW-1:0] rev_low(input logic [MAXW-1:0] d, input logic [4:0] n);
        logic [MAXW-1:0] r;
        r = '0;
        for (int i = 0; i < MAXW; i++)
            if (i < int'(n)) r[int'(n) - 1 - i] = d[i];
        return r;
    endfunction
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // R9: occupancy never exceeds the storage
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_eng_pkg::*;
#(
    parameter int DIVW = 8,
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [1:0]      frame_sel,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            lsb_first,
    input  logic [1:0]      sel_gap,
    input  logic            lead_full,
    input  logic [1:0]      xfer_mode,
    input  logic [DIVW-1:0] half_div,
    input  logic [CNTW-1:0] rx_frames,
    input  logic [MAXW-1:0] tx_head,
    input  logic            tx_empty,
    input  logic            miso,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [MAXW-1:0] rx_word,
    output logic            sclk,
    output logic            mosi,
    output logic            ss_n,
    output logic            busy
);
    eng_state_t      st, st_nx;
    logic [DIVW-1:0] tcnt, hd;
    logic [5:0]      h;
    logic [1:0]      lcnt, lead_n, gap_n;
    logic [MAXW-1:0] tsh, rsh, masked;
    logic [CNTW-1:0] rx_left;
    logic [4:0]      nb;
    logic            rxonly, have_next, tick, frame_end, lead_last, gap_last, load;

    assign nb        = frame_bits(frame_sel);
    assign rxonly    = (xfer_mode == XM_RXONLY);
    assign have_next = en && (rxonly ? (rx_left != '0) : !tx_empty);
    assign hd        = (half_div == '0) ? DIVW'(1) : half_div;
    assign tick      = (st != ST_IDLE) && (tcnt == hd - 1'b1);
    assign lead_n    = lead_full ? 2'd2 : 2'd1;
    assign gap_n     = (sel_gap == 2'd1) ? 2'd1 : 2'd2;
    assign frame_end = (st == ST_SHIFT) && tick && (h == {nb, 1'b0} - 6'd1);
    assign lead_last = (st == ST_LEAD) && tick && (lcnt == lead_n - 2'd1);
    assign gap_last  = (st == ST_GAP) && tick && (lcnt == gap_n - 2'd1);
    assign load      = have_next && ((st == ST_IDLE) || (frame_end && sel_gap == 2'd0) || gap_last);
    assign tx_pop    = load && !rxonly;
    assign rx_push   = frame_end && (xfer_mode != XM_TXONLY);
    assign masked    = lsb_first ? rev_low(rsh, nb) : (rsh & low_mask(nb));
    assign rx_word   = masked;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (have_next) st_nx = ST_LEAD;
            ST_LEAD:  if (lead_last) st_nx = ST_SHIFT;
            ST_SHIFT: if (frame_end)
                          st_nx = (sel_gap != 2'd0) ? ST_GAP : (have_next ? ST_SHIFT : ST_IDLE);
            ST_GAP:   if (gap_last) st_nx = have_next ? ST_LEAD : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt    <= '0;
            lcnt    <= '0;
            h       <= '0;
            tsh     <= '0;
            rsh     <= '0;
            rx_left <= '0;
        end else begin
            tcnt <= (st == ST_IDLE || tick) ? '0 : tcnt + 1'b1;
            if (st_nx != st)  lcnt <= '0;
            else if (tick)    lcnt <= lcnt + 2'd1;
            if (st != ST_SHIFT || frame_end) h <= '0;
            else if (tick)                   h <= h + 6'd1;
            if (load)
                tsh <= rxonly ? '0 :
                       ((lsb_first ? rev_low(tx_head, nb) : (tx_head & low_mask(nb))) << (5'd16 - nb));
            else if (st == ST_SHIFT && tick && h[0])
                tsh <= tsh << 1;
            if (st == ST_SHIFT && tick && !h[0]) rsh <= {rsh[MAXW-2:0], miso};
            if (st == ST_IDLE && !en)  rx_left <= rx_frames;
            else if (load && rxonly)   rx_left <= rx_left - 1'b1;
        end
    end

    always_comb begin
        ss_n = !(st == ST_LEAD || st == ST_SHIFT);
        sclk = cpol ^ ((st == ST_SHIFT) && (h[0] ^ cpha));
        mosi = (st == ST_SHIFT) ? tsh[MAXW-1] : 1'b0;
        busy = (st != ST_IDLE);
    end

    // R2: clock parked at its idle level whenever the select is released
    a_r2_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> (sclk == cpol));
    // R8: receive-only drives zeros on the data pin
    a_r8_rxonly_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && xfer_mode == XM_RXONLY) |-> !mosi);
    // R13: a disabled idle engine stays idle
    a_r13_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !en) |=> (st == ST_IDLE));
    // R5: keep-low mode chains frames without releasing the select
    a_r5_keep_low: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && sel_gap == 2'd0 && have_next) |=> !ss_n);
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          tx_wr,
    input  logic          tx_full,
    input  logic          tx_empty,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] tx_thresh,
    input  logic          rx_rd,
    input  logic          rx_push,
    input  logic          rx_full,
    input  logic          rx_empty,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_thresh,
    input  logic [4:0]    int_mask,
    input  logic          clr_all,
    input  logic          clr_rxu,
    input  logic          clr_rxo,
    input  logic          clr_txo,
    output logic [4:0]    status,
    output logic [4:0]    int_raw,
    output logic [4:0]    int_out
);
    logic txo, rxu, rxo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txo <= 1'b0;
            rxu <= 1'b0;
            rxo <= 1'b0;
        end else begin
            if (clr_all || clr_txo)      txo <= 1'b0;
            else if (tx_wr && tx_full)   txo <= 1'b1;
            if (clr_all || clr_rxu)      rxu <= 1'b0;
            else if (rx_rd && rx_empty)  rxu <= 1'b1;
            if (clr_all || clr_rxo)      rxo <= 1'b0;
            else if (rx_push && rx_full) rxo <= 1'b1;
        end
    end

    assign status  = {rx_full, rx_empty, tx_empty, tx_full, busy};
    assign int_raw = {rx_count >= rx_thresh, rxo, rxu, txo, tx_count <= tx_thresh};
    assign int_out = int_raw & int_mask;

    // R11: clear-all empties every sticky flag on the next cycle
    a_r11_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (int_raw[3:1] == 3'b000));
    // R11: overflow flag holds until a clear arrives
    a_r11_sticky_txo: assert property (@(posedge clk) disable iff (!rst_n)
        (int_raw[1] && !clr_all && !clr_txo) |=> int_raw[1]);
    // R9: full and empty never together
    a_r9_full_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[1] && status[2]) && !(status[3] && status[4]));
endmodule

// File: rtl/spi_serial_engine.sv
module spi_serial_engine
    import spi_eng_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIVW  = 8,
    parameter int CNTW  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [1:0]             frame_sel,
    input  logic                   cpol,
    input  logic                   cpha,
    input  logic                   lsb_first,
    input  logic [1:0]             sel_gap,
    input  logic                   lead_full,
    input  logic [1:0]             xfer_mode,
    input  logic [DIVW-1:0]        half_div,
    input  logic [CNTW-1:0]        rx_frames,
    input  logic [$clog2(DEPTH):0] tx_thresh,
    input  logic [$clog2(DEPTH):0] rx_thresh,
    input  logic                   tx_wr,
    input  logic [15:0]            tx_data,
    input  logic                   rx_rd,
    output logic [15:0]            rx_data,
    input  logic [4:0]             int_mask,
    input  logic                   clr_all,
    input  logic                   clr_rxu,
    input  logic                   clr_rxo,
    input  logic                   clr_txo,
    output logic                   sclk,
    output logic                   mosi,
    output logic                   ss_n,
    input  logic                   miso,
    output logic [4:0]             status,
    output logic [4:0]             int_raw,
    output logic [4:0]             int_out
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [MAXW-1:0] tx_head, rx_word;
    logic [CW-1:0]   tx_count, rx_count;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic            tx_pop, rx_push, busy;

    spi_fifo #(.W(MAXW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_data), .pop(tx_pop),
        .rdata(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty));

    spi_fifo #(.W(MAXW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word), .pop(rx_rd),
        .rdata(rx_data), .count(rx_count), .full(rx_full), .empty(rx_empty));

    spi_shift_fsm #(.DIVW(DIVW), .CNTW(CNTW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .frame_sel(frame_sel), .cpol(cpol),
        .cpha(cpha), .lsb_first(lsb_first), .sel_gap(sel_gap), .lead_full(lead_full),
        .xfer_mode(xfer_mode), .half_div(half_div), .rx_frames(rx_frames),
        .tx_head(tx_head), .tx_empty(tx_empty), .miso(miso), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word), .sclk(sclk), .mosi(mosi),
        .ss_n(ss_n), .busy(busy));

    spi_irq_flags #(.CW(CW)) u_flags (
        .clk(clk), .rst_n(rst_n), .busy(busy), .tx_wr(tx_wr), .tx_full(tx_full),
        .tx_empty(tx_empty), .tx_count(tx_count), .tx_thresh(tx_thresh),
        .rx_rd(rx_rd), .rx_push(rx_push), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_count(rx_count), .rx_thresh(rx_thresh), .int_mask(int_mask),
        .clr_all(clr_all), .clr_rxu(clr_rxu), .clr_rxo(clr_rxo), .clr_txo(clr_txo),
        .status(status), .int_raw(int_raw), .int_out(int_out));
endmodule

// File: tb/tb_spi_serial_engine.sv
`timescale 1ns/1ps
module tb_spi_serial_engine;
    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic [1:0] frame_sel = 2'd1, sel_gap = 2'd0, xfer_mode = 2'd0;
    logic cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0, lead_full = 1'b0;
    logic [7:0] half_div = 8'd2, rx_frames = 8'd0;
    logic [3:0] tx_thresh = 4'd0, rx_thresh = 4'd4;
    logic tx_wr = 1'b0, rx_rd = 1'b0;
    logic [15:0] tx_data = '0, rx_data;
    logic [4:0] int_mask = '0, status, int_raw, int_out;
    logic clr_all = 1'b0, clr_rxu = 1'b0, clr_rxo = 1'b0, clr_txo = 1'b0;
    logic sclk, mosi, ss_n;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_serial_engine dut (
        .clk(clk), .rst_n(rst_n), .en(en), .frame_sel(frame_sel), .cpol(cpol),
        .cpha(cpha), .lsb_first(lsb_first), .sel_gap(sel_gap), .lead_full(lead_full),
        .xfer_mode(xfer_mode), .half_div(half_div), .rx_frames(rx_frames),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .rx_data(rx_data), .int_mask(int_mask), .clr_all(clr_all),
        .clr_rxu(clr_rxu), .clr_rxo(clr_rxo), .clr_txo(clr_txo), .sclk(sclk),
        .mosi(mosi), .ss_n(ss_n), .miso(mosi), .status(status), .int_raw(int_raw),
        .int_out(int_out));

    // pin monitor, sampled on the falling edge
    int tog = 0, falls = 0, since_fall = 0, lead_meas = 0;
    int hi_run = 0, last_hi_run = 0, clk_run = 0, last_clk_run = 0;
    bit seen_tog = 1'b0;
    logic p_ss = 1'b1, p_sclk = 1'b0;
    logic [31:0] cap = '0;
    always @(negedge clk) begin
        clk_run++;
        if (ss_n) hi_run++;
        else begin
            if (p_ss) begin last_hi_run = hi_run; since_fall = 0; seen_tog = 1'b0; falls++; end
            else since_fall++;
            hi_run = 0;
        end
        if (sclk != p_sclk && rst_n) begin
            if (!seen_tog) begin lead_meas = since_fall; seen_tog = 1'b1; end
            if ((tog % 2) == (cpha ? 1 : 0)) cap = {cap[30:0], mosi};
            tog++;
            last_clk_run = clk_run;
            clk_run = 0;
        end
        p_ss = ss_n;
        p_sclk = sclk;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_data = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pop_rx(output int v);
        @(negedge clk); v = int'(rx_data); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic run_xfer();
        int n;
        n = 0;
        @(negedge clk); en = 1'b1;
        @(negedge clk);
        while (status[0] && n < 20000) begin @(negedge clk); n++; end
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 reset status", int'(status), 5'b01100);
        chk("R10 reset raw", int'(int_raw), 5'b00001);
        chk("R2 reset sclk", int'(sclk), 0);
        chk("R9 reset ss_n", int'(ss_n), 1);
    endtask

    task automatic t_basic();
        int t0, v;
        t0 = tog;
        push(16'h00A5);
        run_xfer();
        chk("R1 8-bit toggles", tog - t0, 16);
        chk("R4 msb first on pin", int'(cap[7:0]), 8'hA5);
        chk("R3 cpha0 lead", lead_meas, 4);
        chk("R9 after frame", int'(status), 5'b00100);
        pop_rx(v);
        chk("R7 loopback word", v, 8'hA5);
    endtask

    task automatic t_sizes();
        int t0, v;
        frame_sel = 2'd0; t0 = tog;
        push(16'hFFFC); run_xfer(); pop_rx(v);
        chk("R1 4-bit toggles", tog - t0, 8);
        chk("R1 4-bit word", v, 4'hC);
        frame_sel = 2'd2; t0 = tog;
        push(16'h1234); run_xfer(); pop_rx(v);
        chk("R1 16-bit toggles", tog - t0, 32);
        chk("R1 16-bit word", v, 16'h1234);
        frame_sel = 2'd3; t0 = tog;
        push(16'h3C5A); run_xfer(); pop_rx(v);
        chk("R1 reserved code toggles", tog - t0, 16);
        chk("R1 reserved code word", v, 8'h5A);
        frame_sel = 2'd1;
    endtask

    task automatic t_phase();
        int v;
        cpol = 1'b1; cpha = 1'b1;
        @(negedge clk);
        chk("R2 idle high", int'(sclk), 1);
        push(16'h0096); run_xfer(); pop_rx(v);
        chk("R3 cpha1 lead", lead_meas, 2);
        chk("R3 cpha1 capture", int'(cap[7:0]), 8'h96);
        chk("R2 idle high after", int'(sclk), 1);
        lead_full = 1'b1;
        push(16'h0011); run_xfer(); pop_rx(v);
        chk("R6 full lead", lead_meas, 4);
        chk("R7 cpol1 word", v, 8'h11);
        cpol = 1'b0; cpha = 1'b0; lead_full = 1'b0;
    endtask

    task automatic t_order();
        int v;
        lsb_first = 1'b1;
        push(16'h0001); run_xfer(); pop_rx(v);
        chk("R4 lsb first on pin", int'(cap[7:0]), 8'h80);
        chk("R4 lsb word", v, 1);
        lsb_first = 1'b0;
    endtask

    task automatic t_gaps();
        int f0, v;
        sel_gap = 2'd1; f0 = falls;
        push(16'h0012); push(16'h0034); run_xfer();
        chk("R5 half gap", last_hi_run, 2);
        chk("R5 half gap falls", falls - f0, 2);
        pop_rx(v); pop_rx(v);
        sel_gap = 2'd2; f0 = falls;
        push(16'h0056); push(16'h0078); run_xfer();
        chk("R5 full gap", last_hi_run, 4);
        pop_rx(v); pop_rx(v);
        sel_gap = 2'd0; f0 = falls;
        push(16'h009A); push(16'h00BC); run_xfer();
        chk("R5 keep low falls", falls - f0, 1);
        pop_rx(v); chk("R5 keep low first", v, 8'h9A);
        pop_rx(v); chk("R5 keep low second", v, 8'hBC);
    endtask

    task automatic t_baud();
        int v;
        half_div = 8'd3;
        push(16'h0055); run_xfer(); pop_rx(v);
        chk("R12 half period", last_clk_run, 3);
        chk("R12 lead", lead_meas, 6);
        half_div = 8'd2;
    endtask

    task automatic t_modes();
        int v;
        xfer_mode = 2'd2; rx_frames = 8'd2;
        push(16'h00FF);
        @(negedge clk);
        run_xfer();
        chk("R8 rx-only tx kept", int'(status[2]), 0);
        chk("R8 rx-only zeros", int'(cap[7:0]), 0);
        pop_rx(v); chk("R8 rx-only word 1", v, 0);
        pop_rx(v); chk("R8 rx-only word 2", v, 0);
        chk("R8 rx-only frame count", int'(status[3]), 1);
        rx_frames = 8'd0;
        xfer_mode = 2'd1;
        run_xfer();
        chk("R8 tx-only pin", int'(cap[7:0]), 8'hFF);
        chk("R8 tx-only rx empty", int'(status[3]), 1);
        chk("R8 tx-only tx drained", int'(status[2]), 1);
        xfer_mode = 2'd0;
    endtask

    task automatic t_start();
        @(negedge clk); en = 1'b1;
        repeat (5) @(negedge clk);
        chk("R13 no start on empty", int'(status[0]), 0);
        en = 1'b0;
        push(16'h0042);
        repeat (5) @(negedge clk);
        chk("R13 no start disabled", int'(status[0]), 0);
        chk("R13 word waiting", int'(status[2]), 0);
        begin int v; run_xfer(); pop_rx(v); chk("R13 word sent", v, 8'h42); end
    endtask

    task automatic t_irq();
        int v;
        half_div = 8'd1;
        for (int i = 1; i <= 9; i++) push(16'(i));
        chk("R10 tx overflow", int'(int_raw[1]), 1);
        chk("R9 tx full", int'(status[1]), 1);
        chk("R10 tx level low", int'(int_raw[0]), 0);
        repeat (5) @(negedge clk);
        chk("R11 overflow sticky", int'(int_raw[1]), 1);
        chk("R10 all masked", int'(int_out), 0);
        int_mask = 5'b00010; @(negedge clk);
        chk("R10 mask pass", int'(int_out), 5'b00010);
        pulse(clr_txo);
        chk("R11 clear txo", int'(int_raw[1]), 0);
        run_xfer();
        chk("R9 rx full", int'(status[4]), 1);
        chk("R10 rx level", int'(int_raw[4]), 1);
        chk("R10 tx level", int'(int_raw[0]), 1);
        push(16'h0077); run_xfer();
        chk("R10 rx overflow", int'(int_raw[3]), 1);
        pop_rx(v); chk("R11 oldest kept", v, 1);
        for (int i = 2; i <= 8; i++) pop_rx(v);
        chk("R11 last stored", v, 8);
        pop_rx(v);
        chk("R10 rx underflow", int'(int_raw[2]), 1);
        pulse(clr_all);
        chk("R11 clear all", int'(int_raw[3:1]), 0);
        pop_rx(v);
        pulse(clr_rxu);
        chk("R11 clear rxu", int'(int_raw[2]), 0);
        int_mask = '0; half_div = 8'd2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_sizes();
        t_phase();
        t_order();
        t_gaps();
        t_baud();
        t_modes();
        t_start();
        t_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule